// File: doc/BRIEF.md
# Per-Core Event Timer

This block is a private timer meant to sit beside one processor core. Software reaches it through a narrow coprocessor register port: a register index, a write strobe, write data, and registered read data. There is no bus address decoding. A free-running counter provides a time base that software can read at any moment. A separate countdown produces one-shot events. Software writes a tick count into the load register. When that many clock ticks have passed with the event logic enabled, a pending bit is set and the interrupt line is driven high. The pending bit stays set until software writes to the status register.

Several copies can be placed side by side, one per core. They share nothing except the clock and reset, so each core sees the same register layout and raises the same interrupt number on its own line. Each event is relative to the moment of the load write. Re-arming therefore takes a single write, and the time base is never disturbed.

Top module: `core_event_timer`

## Requirements
- R1: The time-base counter is 0 during reset and increments by one on every clock edge after reset, wrapping modulo 2^CNT_W. Control writes and load writes never change it.
- R2: `rd_data` is registered. One clock after an index is presented, it returns the register value as it stood before that edge. Index 0 returns the enable flag in bit 0, index 1 returns the pending flag in bit 0, index 3 returns the counter zero-extended, and index 6 returns the remaining countdown (0 when nothing is armed). Every other index returns 0, and writes to other indices have no effect.
- R3: A write to index 0 sets the enable flag from data bit 0. Enable is 0 after reset. Writing bit 0 = 0 also cancels any armed countdown. A countdown armed while enable is 0 holds its count, then resumes once enable is set.
- R4: With enable set, a write of N (N >= 2) to index 6 sets the pending flag on exactly the N-th clock edge after the write edge, and not on any earlier edge.
- R5: Load values 0 and 1 are treated as 2.
- R6: A load write while a countdown is armed replaces the remaining count. Timing restarts from the new write.
- R7: After an event fires, the countdown is idle: the remaining count reads 0 and no further event occurs until the next load write.
- R8: Any write to index 1 clears the pending flag, whatever its data. If an event fires on the same edge, the event wins and the flag stays set.
- R9: `irq` equals the pending flag. It stays set while the flag is set, including after enable is cleared.
- R10: A load write on the same edge at which an armed countdown would fire suppresses that event and re-arms with the new value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_idx | input | 4 | Coprocessor register index |
| wr_en | input | 1 | Write strobe for the indexed register |
| wr_data | input | DATA_W | Write data |
| rd_data | output | DATA_W | Registered read data for the index of the previous cycle |
| irq | output | 1 | Timer interrupt, high while an event is pending |

## Verification
The hardest cases to reach are the collisions on the exact edge where a countdown expires: a status clear, or a fresh load, landing on the firing edge. The stimulus gets there by loading the minimum count of 2, idling one cycle, and then issuing the colliding write. Randomly timed replacement loads also cut countdowns short at arbitrary points. A second instance with an 8-bit counter makes the wrap visible within the run, and every read of the counter is compared with the bench's own cycle count.

// File: rtl/cet_pkg.sv
package cet_pkg;
  localparam int REG_IDX_W = 4;
  localparam logic [REG_IDX_W-1:0] IDX_CTRL   = 4'd0;
  localparam logic [REG_IDX_W-1:0] IDX_STATUS = 4'd1;
  localparam logic [REG_IDX_W-1:0] IDX_COUNT  = 4'd3;
  localparam logic [REG_IDX_W-1:0] IDX_LOAD   = 4'd6;
  localparam int MIN_LOAD = 2;
endpackage

// File: rtl/cet_freerun.sv
module cet_freerun #(
  parameter int CNT_W = 32
) (
  input  logic             clk,
  input  logic             rst,
  output logic [CNT_W-1:0] cnt
);
  always_ff @(posedge clk) begin
    if (rst) cnt <= '0;
    else     cnt <= cnt + 1'b1;
  end

  a_r1_step: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) |-> cnt == $past(cnt) + 1'b1);
endmodule

// File: rtl/cet_countdown.sv
module cet_countdown #(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              en,
  input  logic              load_wr,
  input  logic [DATA_W-1:0] load_val,
  input  logic              cancel,
  input  logic              status_wr,
  output logic [DATA_W-1:0] remaining,
  output logic              armed,
  output logic              pending
);
  import cet_pkg::*;

  localparam logic [DATA_W-1:0] MIN_V = DATA_W'(MIN_LOAD);

  logic [DATA_W-1:0] load_clamped;
  logic              fire;

  always_comb begin
    load_clamped = (load_val < MIN_V) ? MIN_V : load_val;
    fire = armed && en && (remaining == DATA_W'(1)) && !load_wr && !cancel;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      remaining <= '0;
      armed     <= 1'b0;
    end else if (load_wr) begin
      remaining <= load_clamped;
      armed     <= 1'b1;
    end else if (cancel || fire) begin
      remaining <= '0;
      armed     <= 1'b0;
    end else if (armed && en) begin
      remaining <= remaining - 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst)            pending <= 1'b0;
    else if (fire)      pending <= 1'b1;
    else if (status_wr) pending <= 1'b0;
  end

  a_r4_fire_origin: assert property (@(posedge clk) disable iff (rst)
    $rose(pending) |-> $past(armed && en && remaining == DATA_W'(1)));
  a_r7_idle_after_fire: assert property (@(posedge clk) disable iff (rst)
    $rose(pending) |-> !armed);
  a_r8_clear: assert property (@(posedge clk) disable iff (rst)
    (status_wr && !(armed && en && remaining == DATA_W'(1) && !load_wr && !cancel)) |=> !pending);
  a_r6_load_arms: assert property (@(posedge clk) disable iff (rst)
    load_wr |=> (armed && remaining >= MIN_V));
  a_r3_cancel: assert property (@(posedge clk) disable iff (rst)
    cancel |=> !armed);
  a_r9_hold: assert property (@(posedge clk) disable iff (rst)
    (pending && !status_wr) |=> pending);
endmodule

// File: rtl/cet_regport.sv
module cet_regport #(
  parameter int DATA_W = 32,
  parameter int CNT_W  = 32
) (
  input  logic                          clk,
  input  logic                          rst,
  input  logic [cet_pkg::REG_IDX_W-1:0] reg_idx,
  input  logic                          wr_en,
  input  logic [DATA_W-1:0]             wr_data,
  input  logic [CNT_W-1:0]              cnt,
  input  logic [DATA_W-1:0]             remaining,
  input  logic                          pending,
  output logic                          en,
  output logic                          load_wr,
  output logic                          cancel,
  output logic                          status_wr,
  output logic [DATA_W-1:0]             rd_data
);
  import cet_pkg::*;

  logic [DATA_W-1:0] cnt_ext;
  logic [DATA_W-1:0] rd_next;
  logic              idx_known;

  generate
    if (CNT_W < DATA_W) begin : g_pad
      assign cnt_ext = {{(DATA_W-CNT_W){1'b0}}, cnt};
    end else begin : g_full
      assign cnt_ext = cnt[DATA_W-1:0];
    end
  endgenerate

  always_comb begin
    load_wr   = wr_en && (reg_idx == IDX_LOAD);
    status_wr = wr_en && (reg_idx == IDX_STATUS);
    cancel    = wr_en && (reg_idx == IDX_CTRL) && !wr_data[0];
    idx_known = 1'b1;
    case (reg_idx)
      IDX_CTRL:   rd_next = {{(DATA_W-1){1'b0}}, en};
      IDX_STATUS: rd_next = {{(DATA_W-1){1'b0}}, pending};
      IDX_COUNT:  rd_next = cnt_ext;
      IDX_LOAD:   rd_next = remaining;
      default: begin
        rd_next   = '0;
        idx_known = 1'b0;
      end
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst)                                 en <= 1'b0;
    else if (wr_en && reg_idx == IDX_CTRL)   en <= wr_data[0];
  end

  always_ff @(posedge clk) begin
    if (rst) rd_data <= '0;
    else     rd_data <= rd_next;
  end

  a_r2_undef_zero: assert property (@(posedge clk) disable iff (rst)
    !idx_known |=> rd_data == '0);
  a_r3_en_write: assert property (@(posedge clk) disable iff (rst)
    (wr_en && reg_idx == IDX_CTRL) |=> en == $past(wr_data[0]));
endmodule

// File: rtl/core_event_timer.sv
module core_event_timer #(
  parameter int DATA_W = 32,
  parameter int CNT_W  = 32
) (
  input  logic                          clk,
  input  logic                          rst,
  input  logic [cet_pkg::REG_IDX_W-1:0] reg_idx,
  input  logic                          wr_en,
  input  logic [DATA_W-1:0]             wr_data,
  output logic [DATA_W-1:0]             rd_data,
  output logic                          irq
);
  logic [CNT_W-1:0]  cnt;
  logic [DATA_W-1:0] remaining;
  logic              armed, pending, en, load_wr, cancel, status_wr;

  cet_freerun #(.CNT_W(CNT_W)) u_freerun (
    .clk(clk), .rst(rst), .cnt(cnt)
  );

  cet_regport #(.DATA_W(DATA_W), .CNT_W(CNT_W)) u_regport (
    .clk(clk), .rst(rst), .reg_idx(reg_idx), .wr_en(wr_en), .wr_data(wr_data),
    .cnt(cnt), .remaining(remaining), .pending(pending), .en(en),
    .load_wr(load_wr), .cancel(cancel), .status_wr(status_wr), .rd_data(rd_data)
  );

  cet_countdown #(.DATA_W(DATA_W)) u_countdown (
    .clk(clk), .rst(rst), .en(en), .load_wr(load_wr), .load_val(wr_data),
    .cancel(cancel), .status_wr(status_wr), .remaining(remaining),
    .armed(armed), .pending(pending)
  );

  assign irq = pending;

  a_r9_irq_matches: assert property (@(posedge clk) disable iff (rst)
    (wr_en && reg_idx == cet_pkg::IDX_STATUS && !$rose(irq)) |=> !irq || $rose(irq));
endmodule

// File: tb/core_event_timer_tb.sv
`timescale 1ns/1ps
module core_event_timer_tb;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [3:0]  reg_idx = '0;
  logic        wr_en = 1'b0;
  logic [31:0] wr_data = '0;
  logic [31:0] rd_data, rd_data_s;
  logic        irq, irq_s;
  int checks = 0, failures = 0, cyc;
  bit done = 0;

  always #2.5 clk = ~clk;

  core_event_timer u_dut (.clk(clk), .rst(rst), .reg_idx(reg_idx), .wr_en(wr_en),
    .wr_data(wr_data), .rd_data(rd_data), .irq(irq));
  core_event_timer #(.CNT_W(8)) u_small (.clk(clk), .rst(rst), .reg_idx(reg_idx),
    .wr_en(wr_en), .wr_data(wr_data), .rd_data(rd_data_s), .irq(irq_s));

  always_ff @(posedge clk) begin
    if (rst) cyc <= 0;
    else     cyc <= cyc + 1;
  end

  function automatic logic [31:0] exp_delay(logic [31:0] n);
    return (n < 2) ? 32'd2 : n;
  endfunction

  function automatic logic [31:0] exp_count(int c, int w);
    logic [31:0] v = 32'(c - 1);
    return (w >= 32) ? v : (v & ((32'd1 << w) - 1));
  endfunction

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic idle(int n);
    wr_en = 1'b0;
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(logic [3:0] idx, logic [31:0] d);
    reg_idx = idx; wr_data = d; wr_en = 1'b1;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(logic [3:0] idx, output logic [31:0] v);
    reg_idx = idx; wr_en = 1'b0;
    @(negedge clk);
    v = rd_data;
  endtask

  task automatic rd_count(string req);
    logic [31:0] v;
    rd(4'd3, v);
    chk(req, v, exp_count(cyc, 32));
    chk(req, rd_data_s, exp_count(cyc, 8));
  endtask

  task automatic expect_fire(logic [31:0] n, string req);
    idle(int'(n) - 1);
    chk(req, {31'd0, irq}, 32'd0);
    idle(1);
    chk(req, {31'd0, irq}, 32'd1);
  endtask

  task automatic clear_irq();
    wr(4'd1, $urandom);
    chk("R8 clear", {31'd0, irq}, 32'd0);
  endtask

  initial begin
    #(200000 * 5.0);
    if (!done) begin
      failures++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    logic [31:0] v;
    void'($urandom(32'd7));
    idle(4);
    chk("R2 reset rd", rd_data, 32'd0);
    chk("R9 reset irq", {31'd0, irq}, 32'd0);
    rst = 1'b0;
    idle(3);
    rd(4'd0, v); chk("R3 enable reset", v, 32'd0);
    rd(4'd1, v); chk("R2 status reset", v, 32'd0);
    rd_count("R1 counter");

    wr(4'd0, 32'd1);
    rd(4'd0, v); chk("R3 enable set", v, 32'd1);

    // R4 basic event
    wr(4'd6, 32'd10); expect_fire(32'd10, "R4 fire");
    rd(4'd1, v); chk("R2 status pending", v, 32'd1);
    clear_irq();
    rd(4'd1, v); chk("R8 status cleared", v, 32'd0);

    // R2 remaining readback
    wr(4'd6, 32'd12);
    rd(4'd6, v); chk("R2 remaining", v, 32'd12);
    expect_fire(32'd11, "R4 fire after read");
    clear_irq();
    rd_count("R1 after loads");

    // R5 minimum clamp
    wr(4'd6, 32'd0); expect_fire(exp_delay(32'd0), "R5 load0"); clear_irq();
    wr(4'd6, 32'd1); expect_fire(exp_delay(32'd1), "R5 load1"); clear_irq();
    wr(4'd6, 32'd2); expect_fire(exp_delay(32'd2), "R5 load2"); clear_irq();

    // R8 fire wins over clear on same edge
    wr(4'd6, 32'd2); idle(1); wr(4'd1, 32'd0);
    chk("R8 fire wins", {31'd0, irq}, 32'd1);
    clear_irq();

    // R10 load on firing edge
    wr(4'd6, 32'd2); idle(1); wr(4'd6, 32'd5);
    chk("R10 suppressed", {31'd0, irq}, 32'd0);
    expect_fire(32'd5, "R10 rearm");
    clear_irq();

    // R7 idle after fire
    idle(50);
    chk("R7 no refire", {31'd0, irq}, 32'd0);
    rd(4'd6, v); chk("R7 remaining zero", v, 32'd0);

    // R3 cancel
    wr(4'd6, 32'd10); idle(3); wr(4'd0, 32'd0); idle(20);
    chk("R3 disabled no fire", {31'd0, irq}, 32'd0);
    wr(4'd0, 32'd1); idle(20);
    chk("R3 cancelled", {31'd0, irq}, 32'd0);
    rd(4'd6, v); chk("R3 cancelled remaining", v, 32'd0);

    // R3 load while disabled holds
    wr(4'd0, 32'd0); wr(4'd6, 32'd4); idle(10);
    chk("R3 hold", {31'd0, irq}, 32'd0);
    rd(4'd6, v); chk("R3 hold count", v, 32'd4);
    wr(4'd0, 32'd1); expect_fire(32'd4, "R3 resume");

    // R9 pending survives disable
    wr(4'd0, 32'd0); idle(5);
    chk("R9 irq held", {31'd0, irq}, 32'd1);
    rd(4'd1, v); chk("R9 status held", v, 32'd1);
    clear_irq(); wr(4'd0, 32'd1);

    // R2 undefined indices
    rd(4'd2, v);  chk("R2 undef 2", v, 32'd0);
    rd(4'd5, v);  chk("R2 undef 5", v, 32'd0);
    rd(4'd15, v); chk("R2 undef 15", v, 32'd0);
    wr(4'd7, 32'hFFFF_FFFF);
    rd(4'd0, v); chk("R2 undef write en", v, 32'd1);
    rd(4'd6, v); chk("R2 undef write load", v, 32'd0);
    chk("R2 undef write irq", {31'd0, irq}, 32'd0);

    // R6 random replacement loads
    for (int i = 0; i < 40; i++) begin
      logic [31:0] n;
      n = 32'd2 + ($urandom % 40);
      if ($urandom % 2) begin
        wr(4'd6, 32'd60 + ($urandom % 100));
        idle($urandom % 12);
        chk("R6 no early fire", {31'd0, irq}, 32'd0);
      end
      wr(4'd6, n);
      expect_fire(exp_delay(n), "R6 random");
      clear_irq();
      rd_count("R1 random");
    end

    // R1 wrap on small instance
    idle(300);
    rd_count("R1 wrap");

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule